// File: doc/BRIEF.md
# DRAM Cycle Type Decoder

This block sits behind the pins of a multiplexed-address asynchronous DRAM interface and watches the four active-low control lines with a fast system clock: row strobe, column strobe, write enable and output enable. It classifies every memory cycle from the order in which those lines fall. The classes are read, early write, late write, read-modify-write, row-only refresh, column-before-row refresh, hidden refresh and standby. It also latches the two address halves that share one bus.

For writes it produces a one-cycle strobe together with the captured write nibble. For reads it produces a single registered enable for the 4-bit common data pins. The enable is never raised in an early write, whatever the output-enable line does.

All control and data inputs cross into the clock domain through two-flop synchronizers. Every output is registered. A change on an input shows at the outputs on the third rising clock edge after it.

Top module: `dram_cycle_decoder`

## Requirements
- R1: On a row-strobe fall the address bus is latched into `row_addr`. On a column-strobe fall while the row strobe is low, the address bus is latched into `col_addr`.
- R2: A column-strobe fall with write enable high is a read, and `cycle_type` becomes 1. While the column strobe stays low, `dq_oe` follows the inverse of `oe_n`. `dq_oe` is low whenever the column strobe is high.
- R3: If write enable is already low when the column strobe falls, the cycle is an early write. In that case `cycle_type` = 2 and `early_wr` = 1, and `dq_oe` stays low even with `oe_n` low.
- R4: If write enable falls after the column strobe with the outputs not driving, the cycle is a late write. In that case `cycle_type` = 3, `early_wr` = 0 and `dq_oe` = 0.
- R5: Each write cycle gives exactly one `wr_stb` pulse, taken at the later of the write-enable and column-strobe falls. `wr_data` holds the data pins sampled at that point.
- R6: If write enable falls while read data is driving, the cycle is a read-modify-write. In that case `cycle_type` = 4 and `dq_oe` stays 1.
- R7: A row-strobe fall with the column strobe high gives `cycle_type` = 5 (row-only refresh). A column-strobe fall before the row-strobe fall gives `cycle_type` = 6 (column-before-row refresh), and that cycle produces no write strobe.
- R8: With both strobes high, `cycle_type` = 0 (standby) and `dq_oe` = 0.
- R9: If the row strobe rises and falls again while the column strobe stays low after a driving read, the read data stays driven. The fall gives `cycle_type` = 7 (hidden refresh) with `dq_oe` = 1.
- R10: If write enable and the column strobe fall in the same sample, the column strobe is taken as first. The cycle is a late write: `cycle_type` = 3, `early_wr` = 0, `dq_oe` = 0.
- R11: Synchronous active-low reset gives `cycle_type` = 0 and clears `dq_oe`, `wr_stb` and `early_wr`. An input change reaches the outputs at the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_in | input | 11 | Multiplexed address bus |
| dq_in | input | 4 | Data pins as seen from the pads |
| row_addr | output | 11 | Latched row half |
| col_addr | output | 11 | Latched column half |
| wr_data | output | 4 | Captured write nibble |
| wr_stb | output | 1 | One-cycle write strobe |
| dq_oe | output | 1 | Drive enable for the data pins |
| early_wr | output | 1 | Early-write flag |
| cycle_type | output | 3 | Decoded cycle class |

## Verification
A table drives each cycle class by putting the control falls in a set order: write enable before the column strobe, after it, in the same sample, and after read data is already out. These tests separate early write, late write and read-modify-write, which differ only in edge order and output state. Further patterns cover the column strobe before the row strobe against the row strobe alone, which separates the two refresh kinds. Directed tests then cover reset, the three-edge latency, output enable toggling within a read, and the row strobe cycling under a held column strobe, which separates hidden refresh from column-before-row refresh.

// File: rtl/dcd_pkg.sv
// Shared types for the DRAM cycle type decoder.
package dcd_pkg;
    typedef enum logic [2:0] {
        CYC_STANDBY  = 3'd0,
        CYC_READ     = 3'd1,
        CYC_EARLY_WR = 3'd2,
        CYC_LATE_WR  = 3'd3,
        CYC_RMW      = 3'd4,
        CYC_ROW_REF  = 3'd5,
        CYC_CBR_REF  = 3'd6,
        CYC_HIDDEN   = 3'd7
    } cyc_t;
endpackage

// File: rtl/dcd_sync.sv
// Two-flop synchronizer for a W-bit group.
// Assumes multi-bit groups are stable around the strobe edges that use them.
module dcd_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcd_edges.sv
// Falling-edge detection on the synchronized active-low strobes.
// Assumes inputs already synchronized; idle level is high.
module dcd_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic s_ras,
    input  logic s_cas,
    input  logic s_we,
    output logic ras_fall,
    output logic cas_fall,
    output logic we_fall
);
    logic p_ras, p_cas, p_we;

    // Registered copies of the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ras <= 1'b1;
            p_cas <= 1'b1;
            p_we  <= 1'b1;
        end else begin
            p_ras <= s_ras;
            p_cas <= s_cas;
            p_we  <= s_we;
        end
    end

    // A fall is high-then-low between consecutive samples.
    always_comb begin
        ras_fall = p_ras & ~s_ras;
        cas_fall = p_cas & ~s_cas;
        we_fall  = p_we  & ~s_we;
    end
endmodule

// File: rtl/dcd_addr_latch.sv
// Latches the row half on a row-strobe fall and the column half on a
// column-strobe fall inside an active row cycle.
module dcd_addr_latch #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_ras,
    input  logic          ras_fall,
    input  logic          cas_fall,
    input  logic [AW-1:0] s_addr,
    output logic [AW-1:0] row_q,
    output logic [AW-1:0] col_q
);
    // Capture each address half at its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (ras_fall)
                row_q <= s_addr;
            if (cas_fall && !s_ras)
                col_q <= s_addr;
        end
    end

    assert_col_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && !s_ras) |=> (col_q == $past(s_addr)));
endmodule

// File: rtl/dcd_cycle_ctrl.sv
// Classifies the cycle from strobe edge order and drives the write strobe,
// the write data register, the early-write flag and the data-pin enable.
// Assumes synchronized active-low inputs and one-sample edge pulses.
module dcd_cycle_ctrl
    import dcd_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_ras,
    input  logic          s_cas,
    input  logic          s_we,
    input  logic          s_oe,
    input  logic          ras_fall,
    input  logic          cas_fall,
    input  logic          we_fall,
    input  logic [DW-1:0] s_dq,
    output cyc_t          cyc_q,
    output logic          oe_q,
    output logic          ew_q,
    output logic          stb_q,
    output logic [DW-1:0] wdat_q
);
    logic rd_class;
    logic wr_take;

    // Classes whose data pins follow the output-enable line.
    always_comb begin
        rd_class = (cyc_q == CYC_READ) || (cyc_q == CYC_RMW) || (cyc_q == CYC_HIDDEN);
    end

    // Write is taken at a column fall with write enable low, or a later write-enable fall in a read.
    always_comb begin
        wr_take = (cas_fall && !s_ras && !s_we && !(s_ras && s_cas))
               || (!cas_fall && !ras_fall && we_fall && !s_cas && !s_ras && cyc_q == CYC_READ);
    end

    // Cycle classification and data-pin enable, in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= CYC_STANDBY;
            oe_q  <= 1'b0;
            ew_q  <= 1'b0;
        end else if (s_ras && s_cas) begin
            cyc_q <= CYC_STANDBY;
            oe_q  <= 1'b0;
        end else if (ras_fall && !s_cas && !cas_fall) begin
            cyc_q <= oe_q ? CYC_HIDDEN : CYC_CBR_REF;
        end else if (ras_fall && s_cas) begin
            cyc_q <= CYC_ROW_REF;
            oe_q  <= 1'b0;
        end else if (cas_fall && !s_ras) begin
            if (!s_we && !we_fall) begin
                cyc_q <= CYC_EARLY_WR;
                ew_q  <= 1'b1;
                oe_q  <= 1'b0;
            end else if (!s_we) begin
                cyc_q <= CYC_LATE_WR;
                ew_q  <= 1'b0;
                oe_q  <= 1'b0;
            end else begin
                cyc_q <= CYC_READ;
                ew_q  <= 1'b0;
                oe_q  <= ~s_oe;
            end
        end else if (we_fall && !s_cas && !s_ras && cyc_q == CYC_READ) begin
            if (oe_q) begin
                cyc_q <= CYC_RMW;
            end else begin
                cyc_q <= CYC_LATE_WR;
                oe_q  <= 1'b0;
            end
        end else if (s_cas) begin
            oe_q <= 1'b0;
        end else if (rd_class) begin
            oe_q <= ~s_oe;
        end
    end

    // Write strobe and captured data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            wdat_q <= '0;
        end else begin
            stb_q <= wr_take;
            if (wr_take)
                wdat_q <= s_dq;
        end
    end

    assert_early_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_EARLY_WR) |-> !oe_q);
    assert_stb_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> (cyc_q == CYC_EARLY_WR || cyc_q == CYC_LATE_WR || cyc_q == CYC_RMW));
    assert_standby_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ras && s_cas) |=> (cyc_q == CYC_STANDBY && !oe_q));
    assert_cas_high_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_cas |=> !oe_q);
    assert_rmw_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_fall && !s_cas && !s_ras && !cas_fall && !ras_fall && cyc_q == CYC_READ && oe_q)
        |=> (cyc_q == CYC_RMW && oe_q));
endmodule

// File: rtl/dram_cycle_decoder.sv
// Top of the DRAM cycle type decoder: synchronizers, edge detection,
// address latch and cycle controller. All outputs are registered.
module dram_cycle_decoder #(
    parameter int AW = 11,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] row_addr,
    output logic [AW-1:0] col_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_stb,
    output logic          dq_oe,
    output logic          early_wr,
    output logic [2:0]    cycle_type
);
    import dcd_pkg::*;

    localparam int BW = AW + DW;

    logic [3:0]    s_ctl;
    logic [BW-1:0] s_bus;
    logic          ras_fall, cas_fall, we_fall;
    cyc_t          cyc;

    dcd_sync #(.W(4), .RST_VAL(4'hF)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({ras_n, cas_n, we_n, oe_n}), .q(s_ctl)
    );

    dcd_sync #(.W(BW), .RST_VAL('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n),
        .d({addr_in, dq_in}), .q(s_bus)
    );

    dcd_edges u_edges (
        .clk(clk), .rst_n(rst_n),
        .s_ras(s_ctl[3]), .s_cas(s_ctl[2]), .s_we(s_ctl[1]),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall)
    );

    dcd_addr_latch #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .s_ras(s_ctl[3]), .ras_fall(ras_fall), .cas_fall(cas_fall),
        .s_addr(s_bus[BW-1:DW]),
        .row_q(row_addr), .col_q(col_addr)
    );

    dcd_cycle_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .s_ras(s_ctl[3]), .s_cas(s_ctl[2]), .s_we(s_ctl[1]), .s_oe(s_ctl[0]),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall),
        .s_dq(s_bus[DW-1:0]),
        .cyc_q(cyc), .oe_q(dq_oe), .ew_q(early_wr),
        .stb_q(wr_stb), .wdat_q(wr_data)
    );

    assign cycle_type = cyc;
endmodule

// File: tb/tb_dram_cycle_decoder.sv
module tb_dram_cycle_decoder;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic ras_n = 1, cas_n = 1, we_n = 1, oe_n = 1;
    logic [10:0] addr_in = '0;
    logic [3:0]  dq_in = '0;
    logic [10:0] row_addr, col_addr;
    logic [3:0]  wr_data;
    logic        wr_stb, dq_oe, early_wr;
    logic [2:0]  cycle_type;

    int checks = 0, errors = 0, stb_cnt = 0;
    logic [3:0] stb_data = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cycle_decoder dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr_in(addr_in), .dq_in(dq_in), .row_addr(row_addr),
        .col_addr(col_addr), .wr_data(wr_data), .wr_stb(wr_stb), .dq_oe(dq_oe),
        .early_wr(early_wr), .cycle_type(cycle_type)
    );

    // Count write strobes seen at the ports.
    always @(negedge clk) if (rst_n && wr_stb) begin
        stb_cnt++;
        stb_data = wr_data;
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1;
        step();
    endtask

    // code: 0 read, 1 early, 2 late, 3 rmw, 4 row ref, 5 cbr, 6 same-sample
    // entry: {code[3:0], type[2:0], oe, stb[1:0], ew[1:0] (2 = skip)}
    localparam logic [11:0] VEC [7] = '{
        {4'd0, 3'd1, 1'b1, 2'd0, 2'd0},
        {4'd1, 3'd2, 1'b0, 2'd1, 2'd1},
        {4'd2, 3'd3, 1'b0, 2'd1, 2'd0},
        {4'd3, 3'd4, 1'b1, 2'd1, 2'd0},
        {4'd4, 3'd5, 1'b0, 2'd0, 2'd2},
        {4'd5, 3'd6, 1'b0, 2'd0, 2'd2},
        {4'd6, 3'd3, 1'b0, 2'd1, 2'd0}
    };

    task automatic run_vec(logic [11:0] v, int idx);
        int code = int'(v[11:8]);
        logic [10:0] row = 11'h100 + 11'(idx * 37);
        logic [10:0] col = 11'h055 + 11'(idx * 91);
        logic [3:0]  d   = 4'(idx + 9);
        int base;
        idle();
        base = stb_cnt;
        addr_in = row;
        case (code)
            0: begin ras_n = 0; step(); addr_in = col; cas_n = 0; oe_n = 0; step(); end
            1: begin ras_n = 0; step(); we_n = 0; dq_in = d; addr_in = col; step();
                     cas_n = 0; oe_n = 0; step(); end
            2: begin ras_n = 0; step(); addr_in = col; cas_n = 0; step();
                     dq_in = d; we_n = 0; step(); end
            3: begin ras_n = 0; step(); addr_in = col; cas_n = 0; oe_n = 0; step();
                     dq_in = d; we_n = 0; step(); end
            4: begin ras_n = 0; step(); end
            5: begin cas_n = 0; step(); ras_n = 0; step(); end
            default: begin ras_n = 0; step(); addr_in = col; dq_in = d;
                     cas_n = 0; we_n = 0; oe_n = 0; step(); end
        endcase
        // R2 R3 R4 R6 R7 R10: class and drive; R5: strobe; R1: addresses
        check($sformatf("R2/R3/R4/R6/R7/R10 type v%0d", idx), int'(cycle_type), int'(v[7:5]));
        check($sformatf("R2/R3/R4/R6 dq_oe v%0d", idx), int'(dq_oe), int'(v[4]));
        check($sformatf("R5 strobe count v%0d", idx), stb_cnt - base, int'(v[3:2]));
        if (v[3:2] != 0) check($sformatf("R5 wr_data v%0d", idx), int'(stb_data), int'(d));
        if (v[1:0] != 2) check($sformatf("R3/R4 early_wr v%0d", idx), int'(early_wr), int'(v[1:0]));
        check($sformatf("R1 row_addr v%0d", idx), int'(row_addr), int'(row));
        if (code <= 3 || code == 6)
            check($sformatf("R1 col_addr v%0d", idx), int'(col_addr), int'(col));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11 reset type", int'(cycle_type), 0);
        check("R11 reset dq_oe", int'(dq_oe), 0);
        check("R11 reset early_wr", int'(early_wr), 0);
        check("R11 reset wr_stb", int'(wr_stb), 0);
        rst_n = 1;
        step();

        foreach (VEC[i]) run_vec(VEC[i], i);

        // R8 standby after a cycle
        idle();
        check("R8 standby type", int'(cycle_type), 0);
        check("R8 standby dq_oe", int'(dq_oe), 0);

        // R11 latency: column fall visible at the third rising edge
        ras_n = 0; oe_n = 0; step();
        cas_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 dq_oe before third edge", int'(dq_oe), 0);
        @(posedge clk); @(negedge clk);
        check("R11 dq_oe at third edge", int'(dq_oe), 1);

        // R2 output enable follows oe_n within a read; column high turns it off
        oe_n = 1; step();
        check("R2 oe_n high", int'(dq_oe), 0);
        oe_n = 0; step();
        check("R2 oe_n low again", int'(dq_oe), 1);
        cas_n = 1; step();
        check("R2 column high", int'(dq_oe), 0);

        // R9 hidden refresh after driving read
        idle();
        ras_n = 0; step(); cas_n = 0; oe_n = 0; step();
        ras_n = 1; step();
        check("R9 drive held with row high", int'(dq_oe), 1);
        ras_n = 0; step();
        check("R9 hidden type", int'(cycle_type), 7);
        check("R9 hidden dq_oe", int'(dq_oe), 1);

        // R3 early write ignores oe_n toggling
        idle();
        ras_n = 0; step(); we_n = 0; step(); cas_n = 0; oe_n = 0; step();
        oe_n = 1; step(); oe_n = 0; step();
        check("R3 early write pins off with oe_n low", int'(dq_oe), 0);
        idle();

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule